// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Sequencer

This block sits in front of the instruction fetch of an 8-bit processor. It owns the master interrupt enable, the halt state, the program counter and the stack pointer. Before each fetch the core raises `step_req`. The sequencer then ANDs the pending-flag byte with the enable byte and chooses one of three outcomes. It can let the fetch proceed. It can keep the core halted for another 4-cycle idle step. Or it can enter an interrupt: it stores the return address on a byte-wide stack in memory, acknowledges one source and redirects the program counter to that source's vector.

The design is a four-state machine. **S_IDLE** waits for a step and accepts the core's commands: load PC/SP, disable, enable, return-from-interrupt and halt. Three transitions leave S_IDLE on a step. **IDLE→DONE (proceed)** is taken when nothing is to be dispatched. **IDLE→DONE (halt hold)** is taken when the core is halted and nothing is pending. **IDLE→PUSH_HI (dispatch)** is taken when an enabled source is pending and the master enable is set. **S_PUSH_HI** writes the high byte of the PC and moves on through **PUSH_HI→PUSH_LO**. **S_PUSH_LO** writes the low byte, pulses the acknowledge mask, loads the vector and moves on through **PUSH_LO→DONE**. **S_DONE** gives a one-cycle result pulse carrying a cycle cost, and **DONE→IDLE** always follows it.

Top module: `irq_dispatch_seq`

## Requirements
- R1: After reset the master enable is 0, the halt state is 0, `sp_out` is 0xFFFE and `pc_out` is 0x0100.
- R2: A step taken while halted with `irq_flag & irq_enable` equal to zero gives `step_done` one cycle later, with `step_cycles`=4 and `fetch_go`=0, and the block stays halted.
- R3: A step taken while halted with `irq_flag & irq_enable` nonzero clears the halt state, even when the master enable is 0. With the enable at 0 the result is `fetch_go`=1 and `step_cycles`=0.
- R4: When the master enable is 0, a step never writes memory and never acknowledges a source. It gives `step_done` with `fetch_go`=1 and `step_cycles`=0 one cycle after the step.
- R5: A dispatch clears the master enable. The enable is already 0 during both stack writes.
- R6: Among the pending enabled sources, the one with the lowest bit index is chosen. During the low-byte write cycle `flag_clr` holds only that bit, and it is zero in every other cycle.
- R7: After a dispatch `pc_out` equals 0x40 + 8 × index. The final `step_done` pulse comes on the cycle after the second write and carries `step_cycles`=12 and `fetch_go`=1.
- R8: A dispatch writes on two consecutive cycles. The first write puts PC[15:8] at SP−1 and the second puts PC[7:0] at SP−2. The final `sp_out` is SP−2.
- R9: In idle, `cmd_di` clears the enable and `cmd_ei` sets it. `cmd_reti` loads `ret_pc` into the PC, adds 2 to SP and sets the enable. If several commands arrive in the same cycle, reti beats ei, and ei beats di.
- R10: In idle with `step_req` low, `upd_valid` loads `pc_in`/`sp_in` (a simultaneous reti takes precedence).
- R11: In idle with `step_req` low, `halt_req` sets the halt state.
- R12: A flag bit whose enable bit is 0 never causes a dispatch and is never chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_req | input | 1 | Request a pre-fetch decision (idle only) |
| halt_req | input | 1 | Enter the halt state |
| cmd_di | input | 1 | Clear master enable |
| cmd_ei | input | 1 | Set master enable |
| cmd_reti | input | 1 | Return from interrupt |
| ret_pc | input | 16 | Popped return address for reti |
| upd_valid | input | 1 | Load PC and SP from the core |
| pc_in | input | 16 | PC value from the core |
| sp_in | input | 16 | SP value from the core |
| irq_flag | input | 8 | Pending interrupt flags |
| irq_enable | input | 8 | Interrupt enable mask |
| pc_out | output | 16 | Current PC |
| sp_out | output | 16 | Current SP |
| ime_out | output | 1 | Master enable |
| halted | output | 1 | Halt state |
| flag_clr | output | 8 | One-hot acknowledge mask for the flag register |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | 16 | Stack write address |
| mem_wdata | output | 8 | Stack write byte |
| step_done | output | 1 | One-cycle result pulse |
| fetch_go | output | 1 | With step_done: proceed to fetch |
| step_cycles | output | 5 | With step_done: cycle cost of the step |

## Verification
Several pending/enable patterns are applied. A pattern with two pending bits (0x0C) shows whether the lowest index wins. A pattern with a pending bit that is masked off (flag 0x03, enable 0x02) shows whether the enable byte takes part in the choice. A single pending bit at index 7 checks the upper end of the vector range, and it is run from a loaded PC/SP, so a wrong byte order or a wrong pre-decrement shows up in the stack addresses and data. The halted cases cover three situations: no pending source, a pending source with the enable cleared, and a pending source with the enable set. Together they separate wake-up from dispatch. Simultaneous commands check the reti/ei/di precedence.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_PUSH_HI = 2'd1,
        S_PUSH_LO = 2'd2,
        S_DONE    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/irq_lowest_pick.sv
// Finds the lowest set bit of a request vector.
module irq_lowest_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/irq_vec_gen.sv
// Turns a source index into its vector address and its acknowledge bit.
module irq_vec_gen #(
    parameter int N          = 8,
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0]     idx,
    output logic [ADDR_W-1:0] vec,
    output logic [N-1:0]      ack
);
    assign vec = ADDR_W'(VEC_BASE) + ADDR_W'(idx) * ADDR_W'(VEC_STRIDE);

    for (genvar g = 0; g < N; g++) begin : g_ack
        assign ack[g] = (idx == IW'(g));
    end
endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq #(
    parameter int NUM_SRC      = 8,
    parameter int DATA_W       = 8,
    parameter int CYC_W        = 5,
    parameter int VEC_BASE     = 'h40,
    parameter int VEC_STRIDE   = 8,
    parameter int RESET_PC     = 'h0100,
    parameter int RESET_SP     = 'hFFFE,
    parameter int HALT_CYC     = 4,
    parameter int DISPATCH_CYC = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_req,
    input  logic                    halt_req,
    input  logic                    cmd_di,
    input  logic                    cmd_ei,
    input  logic                    cmd_reti,
    input  logic [2*DATA_W-1:0]     ret_pc,
    input  logic                    upd_valid,
    input  logic [2*DATA_W-1:0]     pc_in,
    input  logic [2*DATA_W-1:0]     sp_in,
    input  logic [NUM_SRC-1:0]      irq_flag,
    input  logic [NUM_SRC-1:0]      irq_enable,
    output logic [2*DATA_W-1:0]     pc_out,
    output logic [2*DATA_W-1:0]     sp_out,
    output logic                    ime_out,
    output logic                    halted,
    output logic [NUM_SRC-1:0]      flag_clr,
    output logic                    mem_we,
    output logic [2*DATA_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    step_done,
    output logic                    fetch_go,
    output logic [CYC_W-1:0]        step_cycles
);
    import irq_seq_pkg::*;

    localparam int ADDR_W = 2 * DATA_W;
    localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    seq_state_e        state_q, state_d;
    logic              ime_q, halt_q, go_q;
    logic [ADDR_W-1:0] pc_q, sp_q;
    logic [IW-1:0]     sel_q;
    logic [CYC_W-1:0]  cost_q;

    logic              any_pend;
    logic [IW-1:0]     pick_idx;
    logic [ADDR_W-1:0] vec_addr;
    logic [NUM_SRC-1:0] ack_mask;
    logic              take_irq;

    irq_lowest_pick #(.N(NUM_SRC)) u_pick (
        .req (irq_flag & irq_enable),
        .any (any_pend),
        .idx (pick_idx)
    );

    irq_vec_gen #(
        .N(NUM_SRC), .ADDR_W(ADDR_W),
        .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_vec (
        .idx (sel_q),
        .vec (vec_addr),
        .ack (ack_mask)
    );

    assign take_irq = any_pend && ime_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (step_req) state_d = take_irq ? S_PUSH_HI : S_DONE;
            S_PUSH_HI: state_d = S_PUSH_LO;
            S_PUSH_LO: state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ime_q  <= 1'b0;
            halt_q <= 1'b0;
            pc_q   <= ADDR_W'(RESET_PC);
            sp_q   <= ADDR_W'(RESET_SP);
            sel_q  <= '0;
            cost_q <= '0;
            go_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (step_req) begin
                        if (halt_q && !any_pend) begin
                            cost_q <= CYC_W'(HALT_CYC);
                            go_q   <= 1'b0;
                        end else begin
                            halt_q <= 1'b0;
                            if (take_irq) begin
                                ime_q <= 1'b0;
                                sp_q  <= sp_q - 1'b1;
                                sel_q <= pick_idx;
                            end else begin
                                cost_q <= '0;
                                go_q   <= 1'b1;
                            end
                        end
                    end else begin
                        if (upd_valid) begin
                            pc_q <= pc_in;
                            sp_q <= sp_in;
                        end
                        if (cmd_reti) begin
                            pc_q  <= ret_pc;
                            sp_q  <= sp_q + ADDR_W'(2);
                            ime_q <= 1'b1;
                        end else if (cmd_ei) begin
                            ime_q <= 1'b1;
                        end else if (cmd_di) begin
                            ime_q <= 1'b0;
                        end
                        if (halt_req) halt_q <= 1'b1;
                    end
                end
                S_PUSH_HI: sp_q <= sp_q - 1'b1;
                S_PUSH_LO: begin
                    pc_q   <= vec_addr;
                    cost_q <= CYC_W'(DISPATCH_CYC);
                    go_q   <= 1'b1;
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_we      = 1'b0;
        mem_wdata   = '0;
        flag_clr    = '0;
        step_done   = 1'b0;
        fetch_go    = 1'b0;
        step_cycles = '0;
        unique case (state_q)
            S_IDLE: ;
            S_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_wdata = pc_q[ADDR_W-1:DATA_W];
            end
            S_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_wdata = pc_q[DATA_W-1:0];
                flag_clr  = ack_mask;
            end
            S_DONE: begin
                step_done   = 1'b1;
                fetch_go    = go_q;
                step_cycles = cost_q;
            end
            default: ;
        endcase
    end

    assign mem_addr = sp_q;
    assign pc_out   = pc_q;
    assign sp_out   = sp_q;
    assign ime_out  = ime_q;
    assign halted   = halt_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
    parameter int NUM_SRC      = 8,
    parameter int DATA_W       = 8,
    parameter int CYC_W        = 5,
    parameter int HALT_CYC     = 4,
    parameter int DISPATCH_CYC = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_idle,
    input logic                  step_req,
    input logic [NUM_SRC-1:0]    irq_flag,
    input logic [NUM_SRC-1:0]    irq_enable,
    input logic [2*DATA_W-1:0]   pc_out,
    input logic                  ime_out,
    input logic                  halted,
    input logic [NUM_SRC-1:0]    flag_clr,
    input logic                  mem_we,
    input logic [2*DATA_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]     mem_wdata,
    input logic                  step_done,
    input logic                  fetch_go,
    input logic [CYC_W-1:0]      step_cycles
);
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle && step_req && halted && ((irq_flag & irq_enable) == '0)
        |=> step_done && !fetch_go && step_cycles == CYC_W'(HALT_CYC) && halted); // R2

    AST_NO_IME_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle && step_req && !ime_out |=> !mem_we && flag_clr == '0); // R4

    AST_IME_OFF_IN_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !ime_out); // R5

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr) && (flag_clr != '0 -> mem_we)); // R6

    AST_DONE_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> step_done && fetch_go && step_cycles == CYC_W'(DISPATCH_CYC)); // R7

    AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - 1'b1); // R8

    AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> mem_wdata == pc_out[2*DATA_W-1:DATA_W]); // R8
endmodule

bind irq_dispatch_seq irq_dispatch_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .CYC_W(CYC_W),
    .HALT_CYC(HALT_CYC), .DISPATCH_CYC(DISPATCH_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .in_idle(state_q == irq_seq_pkg::S_IDLE),
    .step_req(step_req), .irq_flag(irq_flag), .irq_enable(irq_enable),
    .pc_out(pc_out), .ime_out(ime_out), .halted(halted),
    .flag_clr(flag_clr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .step_done(step_done), .fetch_go(fetch_go),
    .step_cycles(step_cycles)
);

// File: tb/irq_dispatch_seq_tb_top.sv
`timescale 1ns/100ps
module irq_dispatch_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_req = 0, halt_req = 0, cmd_di = 0, cmd_ei = 0, cmd_reti = 0, upd_valid = 0;
    logic [15:0] ret_pc = '0, pc_in = '0, sp_in = '0;
    logic [7:0]  irq_flag = '0, irq_enable = '0;
    logic [15:0] pc_out, sp_out, mem_addr;
    logic        ime_out, halted, mem_we, step_done, fetch_go;
    logic [7:0]  flag_clr, mem_wdata;
    logic [4:0]  step_cycles;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // captured results of one step
    int          n_wr;
    logic [15:0] wa0, wa1;
    logic [7:0]  wd0, wd1, clr_seen;
    logic [4:0]  cyc_seen;
    logic        go_seen, clr_in_lo;

    always #2.5 clk = ~clk;

    irq_dispatch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .halt_req(halt_req),
        .cmd_di(cmd_di), .cmd_ei(cmd_ei), .cmd_reti(cmd_reti), .ret_pc(ret_pc),
        .upd_valid(upd_valid), .pc_in(pc_in), .sp_in(sp_in),
        .irq_flag(irq_flag), .irq_enable(irq_enable),
        .pc_out(pc_out), .sp_out(sp_out), .ime_out(ime_out), .halted(halted),
        .flag_clr(flag_clr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .step_done(step_done), .fetch_go(fetch_go),
        .step_cycles(step_cycles)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_cmd(input bit di, input bit ei, input bit reti, input bit hlt);
        @(negedge clk);
        cmd_di = di; cmd_ei = ei; cmd_reti = reti; halt_req = hlt;
        @(negedge clk);
        cmd_di = 0; cmd_ei = 0; cmd_reti = 0; halt_req = 0;
    endtask

    task automatic load_regs(input logic [15:0] pc, input logic [15:0] sp);
        @(negedge clk);
        pc_in = pc; sp_in = sp; upd_valid = 1;
        @(negedge clk);
        upd_valid = 0;
    endtask

    task automatic run_step();
        n_wr = 0; wa0 = '0; wa1 = '0; wd0 = '0; wd1 = '0;
        clr_seen = '0; cyc_seen = '0; go_seen = 0; clr_in_lo = 0;
        @(negedge clk);
        step_req = 1;
        @(negedge clk);
        step_req = 0;
        for (int k = 0; k < 8; k++) begin
            if (mem_we) begin
                if (n_wr == 0) begin wa0 = mem_addr; wd0 = mem_data_sample(); end
                else begin wa1 = mem_addr; wd1 = mem_data_sample();
                    if (flag_clr != 0) clr_in_lo = 1; end
                n_wr++;
            end
            clr_seen = clr_seen | flag_clr;
            if (step_done) begin
                cyc_seen = step_cycles; go_seen = fetch_go;
                break;
            end
            @(negedge clk);
        end
        if (!step_done) chk("step_done_timeout", 0, 1);
        @(negedge clk);
    endtask

    function automatic logic [7:0] mem_data_sample();
        return mem_wdata;
    endfunction

    task automatic t_reset();
        chk("R1 ime", ime_out, 0);
        chk("R1 halted", halted, 0);
        chk("R1 sp", sp_out, 16'hFFFE);
        chk("R1 pc", pc_out, 16'h0100);
    endtask

    task automatic t_no_ime();
        irq_flag = 8'h04; irq_enable = 8'h04;
        run_step();
        chk("R4 writes", n_wr, 0);
        chk("R4 clr", clr_seen, 0);
        chk("R4 go", go_seen, 1);
        chk("R4 cycles", cyc_seen, 0);
        chk("R4 pc", pc_out, 16'h0100);
        irq_flag = 0; irq_enable = 0;
    endtask

    task automatic t_dispatch_lowest();
        pulse_cmd(0, 1, 0, 0);
        chk("R9 ei", ime_out, 1);
        irq_flag = 8'h0C; irq_enable = 8'hFF;
        run_step();
        chk("R8 writes", n_wr, 2);
        chk("R8 addr hi", wa0, 16'hFFFD);
        chk("R8 data hi", wd0, 8'h01);
        chk("R8 addr lo", wa1, 16'hFFFC);
        chk("R8 data lo", wd1, 8'h00);
        chk("R8 sp", sp_out, 16'hFFFC);
        chk("R6 clr", clr_seen, 8'h04);
        chk("R6 clr in low write", clr_in_lo, 1);
        chk("R7 pc", pc_out, 16'h0050);
        chk("R7 cycles", cyc_seen, 12);
        chk("R7 go", go_seen, 1);
        chk("R5 ime", ime_out, 0);
        irq_flag = 0; irq_enable = 0;
    endtask

    task automatic t_masked();
        pulse_cmd(0, 1, 0, 0);
        irq_flag = 8'h03; irq_enable = 8'h02;
        run_step();
        chk("R12 clr", clr_seen, 8'h02);
        chk("R12 pc", pc_out, 16'h0048);
        irq_flag = 8'h01;
        pulse_cmd(0, 1, 0, 0);
        run_step();
        chk("R12 masked no write", n_wr, 0);
        chk("R12 ime kept", ime_out, 1);
        irq_flag = 0; irq_enable = 0;
    endtask

    task automatic t_top_index();
        load_regs(16'h1234, 16'hC000);
        chk("R10 pc", pc_out, 16'h1234);
        chk("R10 sp", sp_out, 16'hC000);
        irq_flag = 8'h80; irq_enable = 8'h80;
        run_step();
        chk("R8 addr hi", wa0, 16'hBFFF);
        chk("R8 data hi", wd0, 8'h12);
        chk("R8 addr lo", wa1, 16'hBFFE);
        chk("R8 data lo", wd1, 8'h34);
        chk("R7 pc", pc_out, 16'h0078);
        chk("R6 clr", clr_seen, 8'h80);
        irq_flag = 0; irq_enable = 0;
    endtask

    task automatic t_commands();
        ret_pc = 16'h2222;
        pulse_cmd(0, 0, 1, 0);
        chk("R9 reti pc", pc_out, 16'h2222);
        chk("R9 reti sp", sp_out, 16'hC000);
        chk("R9 reti ime", ime_out, 1);
        pulse_cmd(1, 0, 0, 0);
        chk("R9 di", ime_out, 0);
        pulse_cmd(1, 1, 0, 0);
        chk("R9 ei over di", ime_out, 1);
        pulse_cmd(1, 0, 0, 0);
    endtask

    task automatic t_halt();
        pulse_cmd(0, 0, 0, 1);
        chk("R11 halted", halted, 1);
        irq_flag = 8'h01; irq_enable = 8'h00;
        run_step();
        chk("R2 cycles", cyc_seen, 4);
        chk("R2 go", go_seen, 0);
        chk("R2 still halted", halted, 1);
        irq_enable = 8'h01;
        run_step();
        chk("R3 woke", halted, 0);
        chk("R3 go", go_seen, 1);
        chk("R3 cycles", cyc_seen, 0);
        chk("R3 no write", n_wr, 0);
        pulse_cmd(0, 1, 0, 1);
        irq_flag = 8'h30; irq_enable = 8'h20;
        run_step();
        chk("R3 woke ime", halted, 0);
        chk("R5 dispatch pc", pc_out, 16'h0068);
        chk("R5 ime", ime_out, 0);
        irq_flag = 0; irq_enable = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_no_ime();
        t_dispatch_lowest();
        t_masked();
        t_top_index();
        t_commands();
        t_halt();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule